// File: doc/BRIEF.md
# Complementary PWM Dead-Band Generator

This block turns each of four PWM waveforms coming from a timer's compare channels into a complementary pair of gate signals. The low side follows the inverted waveform and the high side follows the waveform itself. After every transition of an input, both members of the pair are held low for a programmable number of clock cycles before the side being switched on is allowed to rise. This keeps the two switches of a half-bridge from conducting together. The rising-edge gap and the falling-edge gap each have their own 8-bit count, and all four generators use the same two counts.

Software writes the two counts into holding registers. A new count reaches the generators only when the timer signals its update event, so a count never changes part-way through a PWM period. When the block is enabled, a per-pin mask chooses which output pins carry the generated signals. Every other pin, and every pin while the block is disabled, carries the ordinary port output value. The block drives pin levels only and does not control pin direction. None of the interfaces carry a data stream, so every pin is a plain level with no valid/ready handshake.

Top module: `dti_top`

## Requirements
- R1: After reset, both active dead counts are zero. With `enable`=1, `ovr_mask`=all ones, `port_out`=0 and `pwm_in`=0, every channel shows low side 1 and high side 0. Channel k drives pin 2k with its low side and pin 2k+1 with its high side.
- R2: The low side and the high side of a channel are never both 1 in the same cycle.
- R3: On a rising edge of `pwm_in[k]`, the low side drops in that same cycle. With an active high-side count H>0, both sides stay low for exactly H cycles, counting the edge cycle, and the high side rises in the cycle after those H cycles.
- R4: On a falling edge of `pwm_in[k]`, the high side drops in that same cycle. With an active low-side count L>0, both sides stay low for exactly L cycles, and the low side then rises.
- R5: An edge that arrives while a dead interval is still running restarts the count, using the count for the new level. Neither side is asserted until the restarted count completes.
- R6: A count of zero adds no delay. In the cycle of the edge, the low side equals `~pwm_in[k]` and the high side equals `pwm_in[k]`.
- R7: A pulse on `lo_dt_wr` or `hi_dt_wr` loads only the holding register. The generators keep using the old count until a cycle in which `tmr_update` is 1, and the new count is in effect from the next cycle.
- R8: With `enable`=0, `pin_out` equals `port_out`. With `enable`=1, pin i takes the generated signal when `ovr_mask[i]`=1 and takes `port_out[i]` otherwise.
- R9: The four generators run independently. An edge on one channel does not disturb the outputs of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; dead counts are in cycles of this clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Enables the override of the port pins |
| tmr_update | input | 1 | Timer update event; moves the holding counts into the active counts |
| lo_dt_wr | input | 1 | Write strobe for the low-side holding count |
| lo_dt_wdata | input | 8 | Low-side dead count (cycles before the low side turns on) |
| hi_dt_wr | input | 1 | Write strobe for the high-side holding count |
| hi_dt_wdata | input | 8 | High-side dead count (cycles before the high side turns on) |
| pwm_in | input | 4 | PWM waveform from each compare channel |
| ovr_mask | input | 8 | Per-pin override select; pin 2k is the low side and pin 2k+1 the high side of channel k |
| port_out | input | 8 | Normal port output levels |
| pin_out | output | 8 | Resulting pin levels |

## Verification
The bench aims at the cycle on which each delayed side turns on. A counter that is off by one would raise the high or low side one cycle early or one cycle late. An input toggle that lands inside a running dead interval checks that the count restarts. A design that let the old count finish would assert the new side too soon. The bench writes new counts and then toggles an input before the update event, which catches a design that applies written counts at once, in the middle of a period. A pass-through test with a zero count catches a design that still inserts a single dead cycle. The mask and disable tests catch pins that are routed to the wrong side or are not released back to the port.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int unsigned DEF_CHANNELS = 4;
  localparam int unsigned DEF_DT_W     = 8;
  localparam int unsigned SIDES        = 2;

  function automatic int unsigned lo_pin(input int unsigned ch);
    return SIDES * ch;
  endfunction

  function automatic int unsigned hi_pin(input int unsigned ch);
    return SIDES * ch + 1;
  endfunction
endpackage

// File: rtl/dti_dbuf.sv
// Holding register plus active register, swapped on the timer update.
module dti_dbuf #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         update,
  output logic [W-1:0] active
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      active <= '0;
    end else begin
      if (wr)     hold_q <= wdata;
      if (update) active <= hold_q;
    end
  end
endmodule

// File: rtl/dti_gen.sv
// One complementary pair with dead interval after each input edge.
module dti_gen #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm,
  input  logic [DT_W-1:0] lo_dt,
  input  logic [DT_W-1:0] hi_dt,
  output logic            lo_q,
  output logic            hi_q
);
  localparam logic [DT_W-1:0] ONE = {{(DT_W-1){1'b0}}, 1'b1};

  logic            prev_q;
  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] load;
  logic            tog;
  logic            busy;

  always_comb begin
    tog  = pwm ^ prev_q;
    load = pwm ? hi_dt : lo_dt;
    busy = tog ? (load != '0) : (cnt_q != '0);
    lo_q = ~pwm & ~busy;
    hi_q =  pwm & ~busy;
  end

  // The edge cycle is the first dead cycle, so the counter holds load-1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= pwm;
      if (tog)
        cnt_q <= (load == '0) ? '0 : load - ONE;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/dti_pinmux.sv
module dti_pinmux #(
  parameter int unsigned PINS = 8
) (
  input  logic            enable,
  input  logic [PINS-1:0] mask,
  input  logic [PINS-1:0] port_out,
  input  logic [PINS-1:0] gen_pins,
  output logic [PINS-1:0] pin_out
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pin_out[i] = (enable && mask[i]) ? gen_pins[i] : port_out[i];
  end
endmodule

// File: rtl/dti_top.sv
module dti_top
  import dti_pkg::*;
#(
  parameter int unsigned CHANNELS = DEF_CHANNELS,
  parameter int unsigned DT_W     = DEF_DT_W,
  localparam int unsigned PINS    = SIDES * CHANNELS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                tmr_update,
  input  logic                lo_dt_wr,
  input  logic [DT_W-1:0]     lo_dt_wdata,
  input  logic                hi_dt_wr,
  input  logic [DT_W-1:0]     hi_dt_wdata,
  input  logic [CHANNELS-1:0] pwm_in,
  input  logic [PINS-1:0]     ovr_mask,
  input  logic [PINS-1:0]     port_out,
  output logic [PINS-1:0]     pin_out
);
  logic [DT_W-1:0]     act_lo;
  logic [DT_W-1:0]     act_hi;
  logic [CHANNELS-1:0] gen_lo;
  logic [CHANNELS-1:0] gen_hi;
  logic [PINS-1:0]     gen_pins;

  dti_dbuf #(.W(DT_W)) u_lo_buf (
    .clk(clk), .rst_n(rst_n), .wr(lo_dt_wr), .wdata(lo_dt_wdata),
    .update(tmr_update), .active(act_lo)
  );

  dti_dbuf #(.W(DT_W)) u_hi_buf (
    .clk(clk), .rst_n(rst_n), .wr(hi_dt_wr), .wdata(hi_dt_wdata),
    .update(tmr_update), .active(act_hi)
  );

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    dti_gen #(.DT_W(DT_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .pwm(pwm_in[k]),
      .lo_dt(act_lo), .hi_dt(act_hi),
      .lo_q(gen_lo[k]), .hi_q(gen_hi[k])
    );
    assign gen_pins[lo_pin(k)] = gen_lo[k];
    assign gen_pins[hi_pin(k)] = gen_hi[k];
  end

  dti_pinmux #(.PINS(PINS)) u_mux (
    .enable(enable), .mask(ovr_mask), .port_out(port_out),
    .gen_pins(gen_pins), .pin_out(pin_out)
  );
endmodule

// File: rtl/dti_chk.sv
module dti_chk #(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned DT_W     = 8,
  parameter int unsigned PINS     = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                tmr_update,
  input logic [CHANNELS-1:0] pwm_in,
  input logic [PINS-1:0]     ovr_mask,
  input logic [PINS-1:0]     port_out,
  input logic [PINS-1:0]     pin_out,
  input logic [DT_W-1:0]     act_lo,
  input logic [DT_W-1:0]     act_hi,
  input logic [CHANNELS-1:0] gen_lo,
  input logic [CHANNELS-1:0] gen_hi
);
  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_lo & gen_hi) == '0);

  p_counts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_update |=> ($stable(act_lo) && $stable(act_hi)));

  p_unmasked_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~ovr_mask) == (port_out & ~ovr_mask));

  p_disabled_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> pin_out == port_out);

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    p_hi_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gen_hi[k]) && act_hi != '0) |-> $past(pwm_in[k]));

    p_lo_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gen_lo[k]) && act_lo != '0) |-> !$past(pwm_in[k]));

    p_restart_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwm_in[k] != $past(pwm_in[k])) &&
       ((pwm_in[k] ? act_hi : act_lo) != '0)) |-> (!gen_lo[k] && !gen_hi[k]));

    p_zero_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_lo == '0 && act_hi == '0) |-> (gen_hi[k] == pwm_in[k] && gen_lo[k] == !pwm_in[k]));
  end
endmodule

bind dti_top dti_chk #(.CHANNELS(CHANNELS), .DT_W(DT_W), .PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tmr_update(tmr_update),
  .pwm_in(pwm_in), .ovr_mask(ovr_mask), .port_out(port_out), .pin_out(pin_out),
  .act_lo(act_lo), .act_hi(act_hi), .gen_lo(gen_lo), .gen_hi(gen_hi)
);

// File: tb/tb_dti_top.sv
module tb_dti_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic       tmr_update;
  logic       lo_dt_wr;
  logic [7:0] lo_dt_wdata;
  logic       hi_dt_wr;
  logic [7:0] hi_dt_wdata;
  logic [3:0] pwm_in;
  logic [7:0] ovr_mask;
  logic [7:0] port_out;
  logic [7:0] pin_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  dti_top dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tmr_update(tmr_update),
    .lo_dt_wr(lo_dt_wr), .lo_dt_wdata(lo_dt_wdata),
    .hi_dt_wr(hi_dt_wr), .hi_dt_wdata(hi_dt_wdata),
    .pwm_in(pwm_in), .ovr_mask(ovr_mask), .port_out(port_out), .pin_out(pin_out)
  );

  // Channel 0 walk with high count 3, low count 2: {pwm0, exp_lo0, exp_hi0}.
  // Channel 2 is held high (pins 10) and channels 1 and 3 low (pins 01).
  localparam int unsigned NVEC = 17;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b010, 3'b100, 3'b100, 3'b100, 3'b101, 3'b000, 3'b000, 3'b010,
    3'b100, 3'b000, 3'b000, 3'b010, 3'b100, 3'b100, 3'b000, 3'b000,
    3'b010
  };

  task automatic check(input logic [7:0] exp, input string req);
    n_checks++;
    if (pin_out !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_out actual %b expected %b", req, pin_out, exp);
    end
  endtask

  // Inputs change just after a rising edge; results are sampled at the falling edge.
  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic sample;
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 1; tmr_update = 0;
    lo_dt_wr = 0; lo_dt_wdata = 0; hi_dt_wr = 0; hi_dt_wdata = 0;
    pwm_in = 4'b0000; ovr_mask = 8'hFF; port_out = 8'h00;
    repeat (3) step();
    rst_n = 1;
    sample();
    check(8'b0101_0101, "R1 reset state");

    // R6: counts are zero, so the edge passes through in its own cycle.
    step(); pwm_in = 4'b0001;
    sample(); check(8'b0101_0110, "R6 zero-count rise");
    step(); pwm_in = 4'b0000;
    sample(); check(8'b0101_0101, "R6 zero-count fall");

    // R7: written counts must not act before the update event.
    step(); hi_dt_wr = 1; hi_dt_wdata = 8'd3; lo_dt_wr = 1; lo_dt_wdata = 8'd2;
    step(); hi_dt_wr = 0; lo_dt_wr = 0; pwm_in = 4'b0001;
    sample(); check(8'b0101_0110, "R7 no effect before update");
    step(); pwm_in = 4'b0000;
    sample(); check(8'b0101_0101, "R7 still pass-through");
    step(); tmr_update = 1;
    step(); tmr_update = 0; pwm_in = 4'b0100;
    sample(); check(8'b0100_0101, "R7 R3 new count active after update");
    repeat (5) step();
    sample(); check(8'b0110_0101, "R9 channel 2 settled high");

    // Table walk on channel 0: R3 rise, R4 fall, R5 restarts, R9 isolation.
    for (int i = 0; i < NVEC; i++) begin
      step();
      pwm_in[0] = VEC[i][2];
      sample();
      check({6'b011001, VEC[i][0], VEC[i][1]}, "R3 R4 R5 R9 vector");
    end

    // R2: both sides of channel 0 never high together in the table above; recheck steady.
    sample(); check(8'b0110_0101, "R2 steady low side only");

    // R8: mask and disable.
    step(); enable = 0; port_out = 8'hA5;
    sample(); check(8'hA5, "R8 disabled gives port");
    step(); enable = 1; ovr_mask = 8'h0F; port_out = 8'h30;
    sample(); check(8'h35, "R8 partial mask");
    step(); ovr_mask = 8'hF0; port_out = 8'h0A;
    sample(); check(8'h6A, "R8 upper mask");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule